// File: doc/BRIEF.md
# Bus-Mapped Bit-Reversed PWM Audio Controller

This block is a two-register bus slave that feeds a one-bit audio modulator. Software writes two's-complement samples into a one-deep pending buffer. A countdown timer produces an interval strobe. On each strobe the pending sample moves into the modulator and the buffer is marked empty. The interrupt line is high whenever the buffer is empty and can take the next sample. The same write that delivers a sample can also update a small group of auxiliary output pins, such as amplifier gain and shutdown, when a guard bit is set.

The modulator compares the bit-reversed value of a free-running counter with the active sample. This gives a one-bit stream with the same count of ones as plain PWM over a full counter period. The ones are spread evenly across that period, so the unwanted energy moves to high frequencies. A design parameter chooses between two rate modes. In fixed mode the interval is a constant. In programmable mode the interval length is held in a second register.

Top module: `audio_mod_ctrl`

## Requirements
- R1: In programmable mode (PROG_RATE=1) the address bit selects the register. A write with address 0 goes to the sample/control register. A write with address 1 loads the interval reload register from wdata[TIMER_W-1:0]. A read with address 1 returns the reload value zero-extended to 32 bits.
- R2: A sample write loads wdata[15:0] into the pending buffer with bit 15 inverted, which turns two's complement into offset binary. It also marks the buffer full.
- R3: The auxiliary outputs take wdata[20 +: AUX_W] on a sample write only when wdata[16] is 1. In every other case they keep their value.
- R4: In fixed mode (PROG_RATE=0) the reload value is the constant DEF_RELOAD. Every write goes to the sample register whatever the address. Reads return the status word whatever the address, combinationally from the current state.
- R5: The interval strobe repeats every L+1 clocks, where L is the reload value in force at the previous strobe. The first strobe comes DEF_RELOAD+1 clocks after reset. At each strobe the pending sample becomes the active sample.
- R6: The strobe empties the buffer unless a sample write happens on the same clock, and then the buffer stays full. irq is high exactly when the buffer is empty.
- R7: The status word is laid out as follows: the active offset-binary sample in [15:0], irq in bit 16, zeros in [19:17], the auxiliary bits from bit 20 upward, and zeros above them. In programmable mode the read data is registered from the state and address at the clock edge that follows the strobe.
- R8: ack is high exactly one clock after every clock with stb high, and low otherwise. stall is always 0.
- R9: After reset the pending and active samples are 0x8000, the buffer is full (irq low), the auxiliary outputs are 0 and the reload value is DEF_RELOAD.
- R10: pwm_out is registered. It goes high in the cycle after a clock edge at which the bit-reversed value of a free-running 16-bit up-counter (0 after reset) is below the active sample. With an active sample of 0xFFFF this gives 65535 ones in 65536 clocks.
- R11: Back-to-back sample writes overwrite the pending sample with no error indication, and the last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Bus strobe, one transfer per high clock |
| bus_we | input | 1 | Write enable for the transfer |
| bus_addr | input | 1 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one clock after strobe |
| bus_stall | output | 1 | Always low |
| bus_rdata | output | 32 | Read data |
| aux_out | output | AUX_W | Auxiliary control pins |
| irq | output | 1 | Buffer-empty interrupt |
| pwm_out | output | 1 | Bit-reversed PWM output |

## Verification
The bench builds two copies that share one bus. The first runs in programmable mode with a reload of 20. The second runs in fixed mode with a reload of 12. Both are compared every clock against a behavioural model. The short intervals put many strobes inside a short run, including strobes that fall on write clocks and reload changes taking effect at the next strobe. Sharing the bus shows on the fixed copy that writes and reads at address 1 land on the sample register. The 16-bit sample width lets one full counter period of 65536 clocks confirm the exact count of ones.

// File: rtl/audio_ctrl_pkg.sv
package audio_ctrl_pkg;
  localparam int SMP_W      = 16;
  localparam int DATA_W     = 32;
  localparam int AUX_EN_BIT = 16;
  localparam int AUX_LSB    = 20;
  localparam int AUX_MAX    = DATA_W - AUX_LSB;

  // two's complement to offset binary
  function automatic logic [SMP_W-1:0] signed_to_offset(input logic [SMP_W-1:0] s);
    return {~s[SMP_W-1], s[SMP_W-2:0]};
  endfunction

  function automatic logic [SMP_W-1:0] bit_reverse(input logic [SMP_W-1:0] v);
    logic [SMP_W-1:0] r;
    for (int i = 0; i < SMP_W; i++) r[i] = v[SMP_W-1-i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic [SMP_W-1:0] act,
                                                    input logic irq_bit,
                                                    input logic [AUX_MAX-1:0] aux);
    return {aux, 3'b000, irq_bit, act};
  endfunction
endpackage

// File: rtl/audio_interval_timer.sv
module audio_interval_timer #(
  parameter int TIMER_W    = 16,
  parameter int DEF_RELOAD = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] reload,
  output logic               strobe
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);
  logic [TIMER_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= TIMER_W'(DEF_RELOAD);
      strobe <= 1'b0;
    end else begin
      strobe <= (remain == ONE);
      remain <= strobe ? reload : remain - ONE;
    end
  end
endmodule

// File: rtl/audio_sample_regs.sv
module audio_sample_regs
  import audio_ctrl_pkg::*;
#(
  parameter int AUX_W      = 2,
  parameter int TIMER_W    = 16,
  parameter bit PROG_RATE  = 1'b1,
  parameter int DEF_RELOAD = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_wr,
  input  logic               reload_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               strobe,
  output logic [SMP_W-1:0]   pending,
  output logic [SMP_W-1:0]   active,
  output logic               valid,
  output logic [AUX_W-1:0]   aux,
  output logic [TIMER_W-1:0] reload
);
  localparam logic [SMP_W-1:0] MIDSCALE = {1'b1, {(SMP_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= MIDSCALE;
      valid   <= 1'b1;
      aux     <= '0;
    end else if (sample_wr) begin
      pending <= signed_to_offset(wdata[SMP_W-1:0]);
      valid   <= 1'b1;
      if (wdata[AUX_EN_BIT]) aux <= wdata[AUX_LSB +: AUX_W];
    end else if (strobe) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active <= MIDSCALE;
    else if (strobe) active <= pending;
  end

  generate
    if (PROG_RATE) begin : g_prog
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         reload <= TIMER_W'(DEF_RELOAD);
        else if (reload_wr) reload <= wdata[TIMER_W-1:0];
      end
    end else begin : g_fixed
      assign reload = TIMER_W'(DEF_RELOAD);
    end
  endgenerate
endmodule

// File: rtl/audio_bitrev_mod.sv
module audio_bitrev_mod
  import audio_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] active,
  output logic             pwm
);
  logic [SMP_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pwm   <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      pwm   <= (bit_reverse(phase) < active);
    end
  end
endmodule

// File: rtl/audio_mod_ctrl.sv
module audio_mod_ctrl
  import audio_ctrl_pkg::*;
#(
  parameter int AUX_W      = 2,
  parameter int TIMER_W    = 16,
  parameter bit PROG_RATE  = 1'b1,
  parameter int DEF_RELOAD = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic              bus_stall,
  output logic [31:0]       bus_rdata,
  output logic [AUX_W-1:0]  aux_out,
  output logic              irq,
  output logic              pwm_out
);
  // named internal events, observed by the bound checker
  logic               sample_wr, reload_wr, strobe, valid;
  logic [SMP_W-1:0]   pending, active;
  logic [TIMER_W-1:0] reload;
  logic [DATA_W-1:0]  status;

  assign sample_wr = bus_stb && bus_we && (!bus_addr || !PROG_RATE);
  assign reload_wr = bus_stb && bus_we &&  bus_addr &&  PROG_RATE;

  audio_interval_timer #(.TIMER_W(TIMER_W), .DEF_RELOAD(DEF_RELOAD)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload), .strobe(strobe));

  audio_sample_regs #(.AUX_W(AUX_W), .TIMER_W(TIMER_W), .PROG_RATE(PROG_RATE),
                      .DEF_RELOAD(DEF_RELOAD)) u_regs (
    .clk(clk), .rst_n(rst_n), .sample_wr(sample_wr), .reload_wr(reload_wr),
    .wdata(bus_wdata), .strobe(strobe), .pending(pending), .active(active),
    .valid(valid), .aux(aux_out), .reload(reload));

  audio_bitrev_mod u_mod (.clk(clk), .rst_n(rst_n), .active(active), .pwm(pwm_out));

  assign irq       = !valid;
  assign bus_stall = 1'b0;
  assign status    = pack_status(active, irq, AUX_MAX'(aux_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= bus_stb;
  end

  generate
    if (PROG_RATE) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bus_rdata <= '0;
        else if (bus_addr) bus_rdata <= DATA_W'(reload);
        else               bus_rdata <= status;
      end
    end else begin : g_rd_comb
      assign bus_rdata = status;
    end
  endgenerate
endmodule

// File: rtl/audio_mod_ctrl_checker.sv
module audio_mod_ctrl_checker #(
  parameter int AUX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb,
  input logic             ack,
  input logic             stall,
  input logic             irq,
  input logic [AUX_W-1:0] aux,
  input logic             sample_wr,
  input logic             strobe,
  input logic [15:0]      pending,
  input logic [15:0]      active,
  input logic [31:0]      wdata
);
  a_r8_ack_after_stb: assert property (@(posedge clk) disable iff (!rst_n) stb |=> ack);
  a_r8_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n) !stb |=> !ack);
  a_r8_stall_low: assert property (@(posedge clk) disable iff (!rst_n) !stall);
  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n) sample_wr |=> !irq);
  a_r6_strobe_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sample_wr) |=> irq);
  a_r2_offset_binary: assert property (@(posedge clk) disable iff (!rst_n)
    sample_wr |=> (pending == {~$past(wdata[15]), $past(wdata[14:0])}));
  a_r3_aux_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_wr && wdata[16]) |=> (aux == $past(wdata[20 +: AUX_W])));
  a_r3_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_wr && wdata[16]) |=> $stable(aux));
  a_r5_active_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (active == $past(pending)));
endmodule

bind audio_mod_ctrl audio_mod_ctrl_checker #(.AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(bus_stb), .ack(bus_ack), .stall(bus_stall),
  .irq(irq), .aux(aux_out), .sample_wr(sample_wr), .strobe(strobe),
  .pending(pending), .active(active), .wdata(bus_wdata));

// File: tb/audio_mod_ctrl_bench.sv
module audio_ref_model #(
  parameter bit PROG   = 1'b1,
  parameter int RELOAD = 20,
  parameter int AUX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             we,
  input  logic             addr,
  input  logic [31:0]      wdata,
  output logic             e_ack,
  output logic             e_irq,
  output logic [AUX_W-1:0] e_aux,
  output logic             e_pwm,
  output logic [31:0]      e_rdata
);
  int   gap, rl, ctr;
  bit   tick, full;
  logic [15:0] pend, act;
  logic [31:0] rdq, stat;

  function automatic int rev16(input int v);
    int r = 0;
    for (int i = 0; i < 16; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  always_comb begin
    stat = {16'h0, act};
    stat = stat | ((full ? 32'd0 : 32'd1) << 16);
    stat = stat | (32'(e_aux) << 20);
  end
  assign e_irq   = !full;
  assign e_rdata = PROG ? rdq : stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= RELOAD; rl <= RELOAD; ctr <= 0; tick <= 0; full <= 1;
      pend <= 16'h8000; act <= 16'h8000; e_aux <= '0; e_ack <= 0; e_pwm <= 0; rdq <= 0;
    end else begin
      bit ws, wr;
      ws = stb && we && (!addr || !PROG);
      wr = stb && we && addr && PROG;
      e_ack <= stb;
      if (ws) begin
        pend <= wdata[15:0] ^ 16'h8000;
        full <= 1;
        if (wdata[16]) e_aux <= wdata[20 +: AUX_W];
      end else if (tick) full <= 0;
      if (wr) rl <= int'(wdata[15:0]);
      if (tick) begin
        act <= pend; tick <= 0; gap <= rl;
      end else begin
        if (gap == 1) tick <= 1;
        gap <= gap - 1;
      end
      e_pwm <= (rev16(ctr) < int'(act));
      ctr <= (ctr + 1) % 65536;
      rdq <= addr ? 32'(rl) : stat;
    end
  end
endmodule

module audio_mod_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic stb = 0, we = 0, addr = 0;
  logic [31:0] wdata = 0;
  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic v_ack, v_stall, v_irq, v_pwm, f_ack, f_stall, f_irq, f_pwm;
  logic [31:0] v_rd, f_rd, ev_rd, ef_rd;
  logic [1:0] v_aux, f_aux, ev_aux, ef_aux;
  logic ev_ack, ev_irq, ev_pwm, ef_ack, ef_irq, ef_pwm;

  always #5 clk = ~clk;

  audio_mod_ctrl #(.AUX_W(2), .TIMER_W(16), .PROG_RATE(1'b1), .DEF_RELOAD(20)) u_audio_mod_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_ack(v_ack), .bus_stall(v_stall), .bus_rdata(v_rd), .aux_out(v_aux), .irq(v_irq),
    .pwm_out(v_pwm));
  audio_mod_ctrl #(.AUX_W(2), .TIMER_W(16), .PROG_RATE(1'b0), .DEF_RELOAD(12)) u_audio_mod_ctrl_fixed (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_ack(f_ack), .bus_stall(f_stall), .bus_rdata(f_rd), .aux_out(f_aux), .irq(f_irq),
    .pwm_out(f_pwm));

  audio_ref_model #(.PROG(1'b1), .RELOAD(20), .AUX_W(2)) u_ref_v (
    .clk(clk), .rst_n(rst_n), .stb(stb), .we(we), .addr(addr), .wdata(wdata),
    .e_ack(ev_ack), .e_irq(ev_irq), .e_aux(ev_aux), .e_pwm(ev_pwm), .e_rdata(ev_rd));
  audio_ref_model #(.PROG(1'b0), .RELOAD(12), .AUX_W(2)) u_ref_f (
    .clk(clk), .rst_n(rst_n), .stb(stb), .we(we), .addr(addr), .wdata(wdata),
    .e_ack(ef_ack), .e_irq(ef_irq), .e_aux(ef_aux), .e_pwm(ef_pwm), .e_rdata(ef_rd));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the behavioural model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R8 ack (prog)", 32'(v_ack), 32'(ev_ack));
      check("R8 ack (fixed)", 32'(f_ack), 32'(ef_ack));
      check("R8 stall", {30'd0, v_stall, f_stall}, 32'd0);
      check("R6 R5 irq (prog)", 32'(v_irq), 32'(ev_irq));
      check("R6 R5 irq (fixed)", 32'(f_irq), 32'(ef_irq));
      check("R3 aux (prog)", 32'(v_aux), 32'(ev_aux));
      check("R3 aux (fixed)", 32'(f_aux), 32'(ef_aux));
      check("R10 pwm (prog)", 32'(v_pwm), 32'(ev_pwm));
      check("R10 pwm (fixed)", 32'(f_pwm), 32'(ef_pwm));
      if (v_ack) check("R7 rdata (prog)", v_rd, ev_rd);
      if (f_ack) check("R7 R4 rdata (fixed)", f_rd, ef_rd);
    end
    if (cycles > 190000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic bus_write(input logic a, input logic [31:0] d);
    stb = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    stb = 0; we = 0; wdata = 0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] rv, output logic [31:0] rf);
    stb = 1; we = 0; addr = a;
    @(negedge clk);
    stb = 0;
    rv = v_rd; rf = f_rd;
  endtask

  task automatic wait_irq_v;
    @(negedge clk);
    for (int i = 0; i < 200 && !v_irq; i++) @(negedge clk);
  endtask

  task automatic wait_irq_f;
    @(negedge clk);
    for (int i = 0; i < 200 && !f_irq; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv, rf;
    int ones_v, ones_f;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check("R9 irq low after reset", {30'd0, v_irq, f_irq}, 32'd0);
    check("R9 aux zero after reset", {28'd0, v_aux, f_aux}, 32'd0);
    bus_read(1'b0, rv, rf);
    check("R9 R7 status after reset (prog)", rv, 32'h0000_8000);
    check("R9 R7 status after reset (fixed)", rf, 32'h0000_8000);
    bus_read(1'b1, rv, rf);
    check("R9 R1 reload read", rv, 32'd20);
    check("R4 fixed read ignores address", rf, 32'h0000_8000);
    // R2 R3 sample with aux update
    bus_write(1'b0, 32'h0031_1234);
    check("R3 aux loaded (prog)", 32'(v_aux), 32'd3);
    check("R2 buffer full after write", {30'd0, v_irq, f_irq}, 32'd0);
    wait_irq_v; wait_irq_f;
    bus_read(1'b0, rv, rf);
    check("R2 R7 status after strobe (prog)", rv, 32'h0031_9234);
    check("R2 R7 status after strobe (fixed)", rf, 32'h0031_9234);
    // R3 aux ignored without enable
    bus_write(1'b0, 32'h0000_5555);
    @(negedge clk);
    check("R3 aux held without enable (prog)", 32'(v_aux), 32'd3);
    check("R3 aux held without enable (fixed)", 32'(f_aux), 32'd3);
    // R1 reload write, R4 same write is a sample in fixed mode
    bus_write(1'b1, 32'd30);
    bus_read(1'b1, rv, rf);
    check("R1 reload readback", rv, 32'd30);
    wait_irq_f;
    bus_read(1'b1, rv, rf);
    check("R4 fixed mode address-1 write is sample", rf, 32'h0031_801E);
    // R11 back-to-back overwrite
    stb = 1; we = 1; addr = 0; wdata = 32'h0000_0100;
    @(negedge clk);
    wdata = 32'h0000_0200;
    @(negedge clk);
    stb = 0; we = 0; wdata = 0;
    wait_irq_v; wait_irq_f;
    bus_read(1'b0, rv, rf);
    check("R11 last write wins (prog)", rv, 32'h0031_8200);
    check("R11 last write wins (fixed)", rf, 32'h0031_8200);
    // R10 ones count over a full counter period
    bus_write(1'b0, 32'h0000_7FFF);
    wait_irq_v; wait_irq_f;
    repeat (3) @(negedge clk);
    ones_v = 0; ones_f = 0;
    for (int i = 0; i < 65536; i++) begin
      ones_v += int'(v_pwm); ones_f += int'(f_pwm);
      @(negedge clk);
    end
    check("R10 ones count (prog)", 32'(ones_v), 32'd65535);
    check("R10 ones count (fixed)", 32'(ones_f), 32'd65535);
    repeat (100) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule